// File: doc/BRIEF.md
# Jitter Attenuator Elastic FIFO

This block is the one-bit-wide elastic store at the centre of a jitter attenuator. Bits arrive on a write strobe that follows a jittered or gapped line clock, and leave on a read strobe that follows a smoothed clock. Both strobes are modelled as enables in a single clock domain. The store can sit in the receive path, or in the transmit path where it evens out a clock with gaps left by removed stuffing bits.

The usable depth is picked at run time as 32 or 64 bits. After reset or a depth change, the store is recentred to half of the chosen depth. This gives a nominal delay of half the depth. When the fill level comes within two bits of either limit, the block raises a bandwidth-widen request for the external phase-locked loop, which is not part of this block. The request drops as soon as the level leaves that guard band. A write to a full store and a read from an empty store are reported as one-cycle pulses.

Top module: `ja_elastic_fifo`

## Requirements
- R1: During and after reset, fill_lvl equals half of the selected depth. widen_req, ovf_pulse, udf_pulse and rd_bit are all 0.
- R2: depth_sel = 0 selects 32 bits and depth_sel = 1 selects 64 bits. A change of depth_sel recentres the store at the next edge, with fill_lvl set to half the new depth. The write and read strobes are ignored in that cycle.
- R3: The first depth/2 reads after a recentre return 0. While reads and writes are balanced, a bit written emerges depth/2 reads later.
- R4: Bits are read out in the order they were written. rd_bit changes only on the edge that performs a read and holds otherwise.
- R5: A lone write raises fill_lvl by 1 and a lone read lowers it by 1. A read and a write in the same cycle leave fill_lvl unchanged when 0 < fill_lvl < depth. fill_lvl never exceeds the depth.
- R6: A write when fill_lvl equals the depth is dropped, and ovf_pulse is high for that one cycle. A read in the same cycle still proceeds.
- R7: A read when fill_lvl is 0 gives rd_bit = 0 and raises udf_pulse for one cycle. A write in the same cycle still proceeds.
- R8: widen_req is high exactly when fill_lvl <= 2 or fill_lvl >= depth - 2. It updates on the same edge as fill_lvl.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both strobes |
| rst | input | 1 | Synchronous active-high reset |
| depth_sel | input | 1 | 0 selects 32-bit depth, 1 selects 64-bit depth |
| wr_en | input | 1 | Write strobe from the jittered side |
| wr_bit | input | 1 | Data bit to store |
| rd_en | input | 1 | Read strobe from the smoothed side |
| rd_bit | output | 1 | Last bit read, registered |
| fill_lvl | output | 7 | Current number of stored bits |
| widen_req | output | 1 | Request to widen the loop bandwidth |
| ovf_pulse | output | 1 | Dropped-write pulse |
| udf_pulse | output | 1 | Empty-read pulse |

## Verification
The bench first streams with the two strobes balanced. This separates the half-depth delay and the zero filler from plain data order. It then runs write-only and read-only sweeps through every fill level at both depths. These hit each guard-band edge, the overflow at full and the underflow at empty, including reads and writes at those limits in the same cycle. Depth changes are made with both strobes active, to show the strobes are ignored. Long pseudo-random strobe mixes compared against a queue model show the pointers wrap correctly at each depth.

// File: rtl/ja_fifo_pkg.sv
package ja_fifo_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_SWAP = 2'b11
  } ja_op_e;

  function automatic ja_op_e op_of(input logic push, input logic pop);
    return ja_op_e'({push, pop});
  endfunction

endpackage

// File: rtl/ja_bit_store.sv
module ja_bit_store #(
  parameter int LG_DEPTH = 6
) (
  input  logic                clk,
  input  logic                we,
  input  logic [LG_DEPTH-1:0] waddr,
  input  logic                wdata,
  input  logic                re,
  input  logic [LG_DEPTH-1:0] raddr,
  output logic                rdata
);
  localparam int ENTRIES = 2 ** LG_DEPTH;

  logic mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ja_ptr_ctrl.sv
module ja_ptr_ctrl
  import ja_fifo_pkg::*;
#(
  parameter int LG_DEPTH = 6,
  localparam int PW = LG_DEPTH + 1
) (
  input  logic                clk,
  input  logic                recenter,
  input  logic                new_sel,
  input  logic                cur_sel,
  input  logic                wr_req,
  input  logic                rd_req,
  output logic                wr_ok,
  output logic                rd_ok,
  output logic                ovf_ev,
  output logic                udf_ev,
  output logic [LG_DEPTH-1:0] wr_addr,
  output logic [LG_DEPTH-1:0] rd_addr,
  output logic [PW-1:0]       wr_ptr,
  output logic [PW-1:0]       rd_ptr,
  output logic [PW-1:0]       fill_q,
  output logic [PW-1:0]       fill_nxt,
  output logic [PW-1:0]       depth_nxt
);
  localparam logic [PW-1:0] D_BIG   = PW'(2 ** LG_DEPTH);
  localparam logic [PW-1:0] D_SMALL = PW'(2 ** (LG_DEPTH - 1));

  logic [PW-1:0]       depth_cur, depth_new, last_idx;
  logic [PW:0]         dbl;
  logic [LG_DEPTH-1:0] amask;
  logic                full, empty;
  ja_op_e              op;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p, input logic [PW-1:0] last);
    return (p == last) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    depth_cur = cur_sel ? D_BIG : D_SMALL;
    depth_new = new_sel ? D_BIG : D_SMALL;
    dbl       = {depth_cur, 1'b0} - (PW+1)'(1);
    last_idx  = dbl[PW-1:0];
    amask     = cur_sel ? {LG_DEPTH{1'b1}} : {1'b0, {(LG_DEPTH-1){1'b1}}};
    wr_addr   = wr_ptr[LG_DEPTH-1:0] & amask;
    rd_addr   = rd_ptr[LG_DEPTH-1:0] & amask;
    full      = (fill_q == depth_cur);
    empty     = (fill_q == '0);
    wr_ok     = wr_req & ~full;
    rd_ok     = rd_req & ~empty;
    ovf_ev    = wr_req & full;
    udf_ev    = rd_req & empty;
    op        = op_of(wr_ok, rd_ok);
    depth_nxt = recenter ? depth_new : depth_cur;
    if (recenter) begin
      fill_nxt = depth_new >> 1;
    end else begin
      unique case (op)
        OP_PUSH: fill_nxt = fill_q + 1'b1;
        OP_POP:  fill_nxt = fill_q - 1'b1;
        default: fill_nxt = fill_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    fill_q <= fill_nxt;
    if (recenter) begin
      wr_ptr <= depth_new >> 1;
      rd_ptr <= '0;
    end else begin
      if (wr_ok) wr_ptr <= bump(wr_ptr, last_idx);
      if (rd_ok) rd_ptr <= bump(rd_ptr, last_idx);
    end
  end
endmodule

// File: rtl/ja_guard_band.sv
module ja_guard_band #(
  parameter int LG_DEPTH = 6,
  parameter int GUARD    = 2,
  localparam int PW = LG_DEPTH + 1
) (
  input  logic          clk,
  input  logic          recenter,
  input  logic [PW-1:0] fill_nxt,
  input  logic [PW-1:0] depth_nxt,
  output logic          widen_q
);
  localparam logic [PW-1:0] G = PW'(GUARD);

  logic near_empty, near_full;

  always_comb begin
    near_empty = (fill_nxt <= G);
    near_full  = (fill_nxt >= depth_nxt - G);
  end

  always_ff @(posedge clk) begin
    if (recenter) widen_q <= 1'b0;
    else          widen_q <= near_empty | near_full;
  end
endmodule

// File: rtl/ja_elastic_fifo.sv
module ja_elastic_fifo #(
  parameter int LG_DEPTH = 6,
  parameter int GUARD    = 2,
  localparam int PW = LG_DEPTH + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          depth_sel,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          rd_en,
  output logic          rd_bit,
  output logic [PW-1:0] fill_lvl,
  output logic          widen_req,
  output logic          ovf_pulse,
  output logic          udf_pulse
);
  logic                cur_sel, recenter, wr_req, rd_req;
  logic                wr_ok, rd_ok, ovf_ev, udf_ev, mem_q, zero_q;
  logic [LG_DEPTH-1:0] wr_addr, rd_addr;
  logic [PW-1:0]       wr_ptr, rd_ptr, fill_q, fill_nxt, depth_nxt, filler_q;

  always_comb begin
    recenter = rst | (depth_sel != cur_sel);
    wr_req   = wr_en & ~recenter;
    rd_req   = rd_en & ~recenter;
  end

  ja_ptr_ctrl #(.LG_DEPTH(LG_DEPTH)) u_ptr (
    .clk(clk), .recenter(recenter), .new_sel(depth_sel), .cur_sel(cur_sel),
    .wr_req(wr_req), .rd_req(rd_req), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .ovf_ev(ovf_ev), .udf_ev(udf_ev), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .fill_q(fill_q), .fill_nxt(fill_nxt),
    .depth_nxt(depth_nxt)
  );

  ja_bit_store #(.LG_DEPTH(LG_DEPTH)) u_store (
    .clk(clk), .we(wr_ok), .waddr(wr_addr), .wdata(wr_bit),
    .re(rd_ok), .raddr(rd_addr), .rdata(mem_q)
  );

  ja_guard_band #(.LG_DEPTH(LG_DEPTH), .GUARD(GUARD)) u_guard (
    .clk(clk), .recenter(recenter), .fill_nxt(fill_nxt),
    .depth_nxt(depth_nxt), .widen_q(widen_req)
  );

  always_ff @(posedge clk) begin
    cur_sel <= depth_sel;
    if (recenter) begin
      ovf_pulse <= 1'b0;
      udf_pulse <= 1'b0;
      zero_q    <= 1'b1;
      filler_q  <= fill_nxt;
    end else begin
      ovf_pulse <= ovf_ev;
      udf_pulse <= udf_ev;
      if (rd_req) zero_q <= udf_ev | (filler_q != '0);
      if (rd_ok && filler_q != '0) filler_q <= filler_q - 1'b1;
    end
  end

  assign rd_bit   = mem_q & ~zero_q;
  assign fill_lvl = fill_q;
endmodule

// File: rtl/ja_elastic_fifo_chk.sv
module ja_elastic_fifo_chk #(
  parameter int LG_DEPTH = 6,
  parameter int GUARD    = 2,
  localparam int PW = LG_DEPTH + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          cur_sel,
  input logic [PW-1:0] fill_lvl,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          widen_req,
  input logic          ovf_pulse,
  input logic          udf_pulse,
  input logic          rd_bit
);
  logic [PW:0] dep, gap;

  always_comb begin
    dep = cur_sel ? (PW+1)'(2 ** LG_DEPTH) : (PW+1)'(2 ** (LG_DEPTH - 1));
    if (wr_ptr >= rd_ptr) gap = {1'b0, wr_ptr} - {1'b0, rd_ptr};
    else                  gap = {1'b0, wr_ptr} + {dep, 1'b0} - {1'b0, rd_ptr};
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    {1'b0, fill_lvl} <= dep);  // R5
  AST_PTR_GAP: assert property (@(posedge clk) disable iff (rst)
    gap == {1'b0, fill_lvl});  // R5
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    (cur_sel == $past(cur_sel)) |->
      ((fill_lvl == $past(fill_lvl)) || (fill_lvl == $past(fill_lvl) + 1'b1) ||
       (fill_lvl == $past(fill_lvl) - 1'b1)));  // R5
  AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> ({1'b0, $past(fill_lvl)} == $past(dep)));  // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ovf_pulse && udf_pulse));  // R6
  AST_UDF_ZERO: assert property (@(posedge clk) disable iff (rst)
    udf_pulse |-> (!rd_bit && $past(fill_lvl) == '0));  // R7
  AST_WIDEN_BAND: assert property (@(posedge clk) disable iff (rst)
    widen_req == ((fill_lvl <= PW'(GUARD)) || ({1'b0, fill_lvl} >= dep - (PW+1)'(GUARD))));  // R8
endmodule

bind ja_elastic_fifo ja_elastic_fifo_chk #(.LG_DEPTH(LG_DEPTH), .GUARD(GUARD)) u_chk (
  .clk(clk), .rst(rst), .cur_sel(cur_sel), .fill_lvl(fill_lvl),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .widen_req(widen_req),
  .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse), .rd_bit(rd_bit)
);

// File: tb/ja_elastic_fifo_test.sv
`timescale 1ns/1ps
module ja_elastic_fifo_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       depth_sel = 1'b0;
  logic       wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0;
  logic       rd_bit, widen_req, ovf_pulse, udf_pulse;
  logic [6:0] fill_lvl;

  int checks = 0, errors = 0;
  int cnt, msel;
  logic mq [0:63];
  logic e_rd, e_ovf, e_udf;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  ja_elastic_fifo uut (
    .clk(clk), .rst(rst), .depth_sel(depth_sel), .wr_en(wr_en), .wr_bit(wr_bit),
    .rd_en(rd_en), .rd_bit(rd_bit), .fill_lvl(fill_lvl), .widen_req(widen_req),
    .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dep_of(input int s);
    return (s != 0) ? 64 : 32;
  endfunction

  task automatic model_center(input int s);
    msel = s;
    cnt = dep_of(s) / 2;
    for (int i = 0; i < 64; i++) mq[i] = 1'b0;
    e_rd = 1'b0; e_ovf = 1'b0; e_udf = 1'b0;
  endtask

  task automatic check_all();
    int d = dep_of(msel);
    chk(fill_lvl, cnt, "R5 fill");
    chk(widen_req, (cnt <= 2 || cnt >= d - 2) ? 1 : 0, "R8 widen");
    chk(ovf_pulse, e_ovf, "R6 ovf");
    chk(udf_pulse, e_udf, "R7 udf");
    chk(rd_bit, e_rd, "R4 rd_bit");
  endtask

  task automatic step(input logic w, input logic wb, input logic r, input logic s);
    int d;
    @(negedge clk);
    wr_en = w; wr_bit = wb; rd_en = r; depth_sel = s;
    @(posedge clk);
    #1;
    if (int'(s) != msel) begin
      model_center(int'(s));
      chk(fill_lvl, dep_of(msel) / 2, "R2 recentre on depth change");
    end else begin
      d = dep_of(msel);
      e_ovf = w && cnt == d;
      e_udf = r && cnt == 0;
      if (r) begin
        if (cnt > 0) begin
          e_rd = mq[0];
          for (int i = 0; i < 63; i++) mq[i] = mq[i+1];
          cnt--;
        end else e_rd = 1'b0;
      end
      if (w && !e_ovf) begin
        mq[cnt] = wb;
        cnt++;
      end
    end
    check_all();
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk);
    rst = 1'b1; depth_sel = s; wr_en = 1'b1; rd_en = 1'b1;
    @(posedge clk); @(posedge clk);
    #1;
    model_center(int'(s));
    check_all();  // R1 during reset
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic next_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run_depth(input logic s);
    int d = dep_of(int'(s));
    do_reset(s);
    // R1: state right after reset
    chk(fill_lvl, d / 2, "R1 reset fill");
    chk(widen_req, 0, "R1 reset widen");
    chk(rd_bit, 0, "R1 reset rd_bit");
    // R3: balanced streaming, filler zeros then delayed data
    for (int k = 0; k < d + 8; k++) begin
      logic b = logic'((k * 5 + 1) % 3 == 0);
      step(1'b1, b, 1'b1, s);
      if (k < d / 2) chk(rd_bit, 0, "R3 filler zero");
      else           chk(rd_bit, ((((k - d / 2) * 5 + 1) % 3) == 0) ? 1 : 0, "R3 half-depth delay");
    end
    // write-only sweep to full and beyond
    for (int k = 0; k < d / 2 + 3; k++) step(1'b1, logic'(k % 2), 1'b0, s);
    chk(ovf_pulse, 1, "R6 overflow seen");
    step(1'b1, 1'b1, 1'b1, s);  // R6 read proceeds at full
    step(1'b1, 1'b0, 1'b0, s);
    // read-only sweep to empty and beyond
    for (int k = 0; k < d + 3; k++) step(1'b0, 1'b0, 1'b1, s);
    chk(udf_pulse, 1, "R7 underflow seen");
    step(1'b1, 1'b1, 1'b1, s);  // R7 write proceeds at empty
    chk(fill_lvl, 1, "R7 write at empty kept");
    // pseudo-random mixes with drifting bias
    for (int k = 0; k < 1200; k++) begin
      int thr = ((k / 150) % 2 == 0) ? 11 : 5;
      next_lfsr();
      step(logic'(lfsr[3:0] < 4'(thr)), lfsr[7], logic'(lfsr[11:8] < 4'(16 - thr)), s);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    msel = 0; cnt = 16;
    run_depth(1'b0);
    run_depth(1'b1);
    // R2: depth change mid-run with strobes active is ignored for data
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b1, 1'b0);
    chk(ovf_pulse, 0, "R2 strobes ignored on change");
    chk(rd_bit, 0, "R2 output cleared on change");
    step(1'b1, 1'b1, 1'b1, 1'b1);
    chk(fill_lvl, 32, "R2 64-bit centre");
    for (int k = 0; k < 40; k++) step(1'b1, 1'b1, 1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule